// File: doc/BRIEF.md
# Mode-Configurable Multiply-Add Slice

This block is an arithmetic slice built around four 18×18 multipliers. Each instance is set at elaboration to one of four operating modes: plain products, a running multiply-accumulate, two sums of product pairs, or one sum of all four products. In plain-product mode each multiplier can be split into two 9×9 multipliers, so the slice can present eight narrow products instead of four wide ones. A selector placed after the adder and accumulator stage routes the raw products, the accumulator or the summation result onto one 144-bit result bus.

The result bus is divided into four 36-bit lanes. When output registers are built in, each lane has its own register with a load enable and an asynchronous clear. Without them the selector output goes straight to the port. A single sign control applies to every multiplier and chooses between two's-complement and unsigned operands. Each product pair has its own add/subtract control. The accumulator has a synchronous clear that loads the current product.

Operand lane i occupies bits [18i+17:18i] of `a_i` and `b_i`. Result lane i occupies bits [36i+35:36i] of `result_o`.

Top module: `dsp_mode_slice`

## Requirements
- R1: In plain-product mode with no split, result lane i holds the low 36 bits of operand lane i of `a_i` times operand lane i of `b_i`.
- R2: In plain-product mode with SPLIT=1, bits [17:0] of result lane i hold the product of the low 9-bit halves of the two operand lanes, and bits [35:18] hold the product of the high 9-bit halves.
- R3: `signed_i`=1 treats both operands of every multiplier, and of every half multiplier, as two's complement. `signed_i`=0 treats them as unsigned.
- R4: In pair-sum mode, bits [72p+71:72p] hold the sign-extended value A(2p)·B(2p)+A(2p+1)·B(2p+1). The sum becomes a difference when `sub_i[p]`=1.
- R5: In quad-sum mode, all 144 result bits hold the sign-extended sum of the two pair results, each pair formed as in R4.
- R6: In accumulate mode, a clock edge with `acc_en_i`=1 and `acc_clr_i`=0 adds A0·B0 to the 52-bit accumulator, or subtracts it when `sub_i[0]`=1. The result bus carries the accumulator sign-extended to 144 bits.
- R7: A clock edge with `acc_clr_i`=1 loads A0·B0 into the accumulator whatever the value of `acc_en_i`.
- R8: When `acc_en_i` and `acc_clr_i` are both 0, the accumulator and its output hold while the operands change.
- R9: With OUT_REG=1, lane g is captured one clock edge after its input settles, and only when `oreg_en_i[g]`=1. Otherwise it keeps its value.
- R10: `oreg_clr_i[g]`=1 zeroes lane g at once, without a clock edge and ahead of the enable, and holds it at zero while it stays high.
- R11: `rst_ni`=0 zeroes all output registers and the accumulator asynchronously.
- R12: With OUT_REG=0, product and sum results reach `result_o` in the same cycle the operands change, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 4*OPW | Multiplicand lanes |
| b_i | input | 4*OPW | Multiplier lanes |
| signed_i | input | 1 | 1: two's-complement operands, 0: unsigned |
| sub_i | input | 2 | Per-pair subtract select (bit 0 also sets the accumulate direction) |
| acc_en_i | input | 1 | Accumulate on this edge |
| acc_clr_i | input | 1 | Load product into accumulator on this edge |
| oreg_en_i | input | 4 | Per-lane output register load enable |
| oreg_clr_i | input | 4 | Per-lane asynchronous output clear |
| result_o | output | 8*OPW | Selected result, four lanes of 2*OPW bits |

## Verification
The bench builds five instances, all with OPW=18 and ACC_W=52. Two are plain-product slices: one registered and unsplit, one unregistered and split. The others are an unregistered accumulator, an unregistered pair-sum slice and a registered quad-sum slice. Together they cover every mode, both output-register variants and the 9×9 split. Sharing one set of operand vectors lets the same signed and unsigned corner values, such as the most negative operand and all-ones, reach every path at once. The registered instances are also where per-lane enable, asynchronous clear and reset are tested.

// File: rtl/dsp_slice_pkg.sv
package dsp_slice_pkg;
  typedef enum logic [1:0] {MODE_MUL, MODE_MAC, MODE_SUM2, MODE_SUM4} slice_mode_e;
  localparam int unsigned NLANE = 4;
  localparam int unsigned NPAIR = NLANE / 2;
endpackage

// File: rtl/dsp_slice_lane.sv
module dsp_slice_lane #(
  parameter int unsigned OPW   = 18,
  parameter bit          SPLIT = 1'b0
) (
  input  logic [OPW-1:0]          a_i,
  input  logic [OPW-1:0]          b_i,
  input  logic                    signed_i,
  output logic signed [2*OPW+1:0] prod_o,
  output logic [2*OPW-1:0]        raw_o
);
  localparam int unsigned PW = 2*OPW + 2;

  logic signed [PW-1:0] ax, bx;
  assign ax = {{(PW-OPW){signed_i & a_i[OPW-1]}}, a_i};
  assign bx = {{(PW-OPW){signed_i & b_i[OPW-1]}}, b_i};
  assign prod_o = ax * bx;

  if (SPLIT) begin : g_split
    localparam int unsigned HW  = OPW / 2;
    localparam int unsigned HPW = 2*HW + 2;
    logic signed [HPW-1:0] al, bl, ah, bh, pl, ph;
    assign al = {{(HPW-HW){signed_i & a_i[HW-1]}},   a_i[HW-1:0]};
    assign bl = {{(HPW-HW){signed_i & b_i[HW-1]}},   b_i[HW-1:0]};
    assign ah = {{(HPW-HW){signed_i & a_i[2*HW-1]}}, a_i[2*HW-1:HW]};
    assign bh = {{(HPW-HW){signed_i & b_i[2*HW-1]}}, b_i[2*HW-1:HW]};
    assign pl = al * bl;
    assign ph = ah * bh;
    assign raw_o = {ph[2*HW-1:0], pl[2*HW-1:0]};
    logic unused_split;
    assign unused_split = ^{pl[HPW-1:2*HW], ph[HPW-1:2*HW]};
  end else begin : g_full
    assign raw_o = prod_o[2*OPW-1:0];
  end
endmodule

// File: rtl/dsp_slice_core.sv
module dsp_slice_core import dsp_slice_pkg::*; #(
  parameter slice_mode_e MODE  = MODE_MUL,
  parameter int unsigned OPW   = 18,
  parameter int unsigned ACC_W = 52
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic signed [2*OPW+1:0]   prod_i [NLANE],
  input  logic [NLANE*2*OPW-1:0]    raw_i,
  input  logic [NPAIR-1:0]          sub_i,
  input  logic                      acc_en_i,
  input  logic                      acc_clr_i,
  output logic [NLANE*2*OPW-1:0]    sel_o
);
  localparam int unsigned PW = 2*OPW + 2;
  localparam int unsigned LW = 2*OPW;
  localparam int unsigned RW = NLANE*LW;

  if (MODE == MODE_MUL) begin : g_mul
    assign sel_o = raw_i;
    logic unused_mul;
    assign unused_mul = ^{clk_i, rst_ni, acc_en_i, acc_clr_i, sub_i,
                          prod_i[0], prod_i[1], prod_i[2], prod_i[3]};
  end else if (MODE == MODE_MAC) begin : g_mac
    logic signed [ACC_W-1:0] acc_q, prod_x;
    assign prod_x = ACC_W'(prod_i[0]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        acc_q <= '0;
      else if (acc_clr_i) acc_q <= prod_x;
      else if (acc_en_i)  acc_q <= sub_i[0] ? acc_q - prod_x : acc_q + prod_x;
    end

    assign sel_o = RW'(acc_q);

    logic unused_mac;
    assign unused_mac = ^{raw_i, sub_i[NPAIR-1:1], prod_i[1], prod_i[2], prod_i[3]};

    // R7
    acc_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_clr_i |=> acc_q == $past(prod_x));
    // R8
    acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!acc_clr_i && !acc_en_i) |=> $stable(acc_q));
    // R6
    acc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_en_i && !acc_clr_i && !sub_i[0]) |=> acc_q == $past(acc_q) + $past(prod_x));
  end else begin : g_sum
    logic signed [PW:0] pair [NPAIR];
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      logic signed [PW:0] x, y;
      assign x = (PW+1)'(prod_i[2*p]);
      assign y = (PW+1)'(prod_i[2*p+1]);
      assign pair[p] = sub_i[p] ? x - y : x + y;
    end

    if (MODE == MODE_SUM2) begin : g_two
      for (genvar p = 0; p < NPAIR; p++) begin : g_out
        assign sel_o[p*2*LW +: 2*LW] = (2*LW)'(pair[p]);
      end
    end else begin : g_four
      logic signed [PW+1:0] quad;
      assign quad = (PW+2)'(pair[0]) + (PW+2)'(pair[1]);
      assign sel_o = RW'(quad);
    end

    logic unused_sum;
    assign unused_sum = ^{clk_i, rst_ni, acc_en_i, acc_clr_i, raw_i};
  end
endmodule

// File: rtl/dsp_slice_oreg.sv
module dsp_slice_oreg #(
  parameter int unsigned W = 36
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         aclr_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni or posedge aclr_i) begin
    if (!rst_ni)     q_o <= '0;
    else if (aclr_i) q_o <= '0;
    else if (en_i)   q_o <= d_i;
  end

  // R10
  oreg_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aclr_i |-> q_o == '0);
  // R9
  oreg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !aclr_i) ##1 !aclr_i |-> $stable(q_o));
  // R9
  oreg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !aclr_i) ##1 !aclr_i |-> q_o == $past(d_i));
endmodule

// File: rtl/dsp_mode_slice.sv
module dsp_mode_slice import dsp_slice_pkg::*; #(
  parameter slice_mode_e MODE    = MODE_MUL,
  parameter int unsigned OPW     = 18,
  parameter bit          SPLIT   = 1'b0,
  parameter bit          OUT_REG = 1'b1,
  parameter int unsigned ACC_W   = 52
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NLANE*OPW-1:0]   a_i,
  input  logic [NLANE*OPW-1:0]   b_i,
  input  logic                   signed_i,
  input  logic [NPAIR-1:0]       sub_i,
  input  logic                   acc_en_i,
  input  logic                   acc_clr_i,
  input  logic [NLANE-1:0]       oreg_en_i,
  input  logic [NLANE-1:0]       oreg_clr_i,
  output logic [NLANE*2*OPW-1:0] result_o
);
  localparam int unsigned LW         = 2*OPW;
  localparam bit          LANE_SPLIT = SPLIT && (MODE == MODE_MUL);

  logic signed [2*OPW+1:0] prod [NLANE];
  logic [NLANE*LW-1:0]     raw;
  logic [NLANE*LW-1:0]     sel;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    dsp_slice_lane #(.OPW(OPW), .SPLIT(LANE_SPLIT)) u_lane (
      .a_i      (a_i[i*OPW +: OPW]),
      .b_i      (b_i[i*OPW +: OPW]),
      .signed_i (signed_i),
      .prod_o   (prod[i]),
      .raw_o    (raw[i*LW +: LW])
    );
  end

  dsp_slice_core #(.MODE(MODE), .OPW(OPW), .ACC_W(ACC_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prod_i    (prod),
    .raw_i     (raw),
    .sub_i     (sub_i),
    .acc_en_i  (acc_en_i),
    .acc_clr_i (acc_clr_i),
    .sel_o     (sel)
  );

  if (OUT_REG) begin : g_oreg
    for (genvar g = 0; g < NLANE; g++) begin : g_grp
      dsp_slice_oreg #(.W(LW)) u_oreg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .aclr_i (oreg_clr_i[g]),
        .en_i   (oreg_en_i[g]),
        .d_i    (sel[g*LW +: LW]),
        .q_o    (result_o[g*LW +: LW])
      );
    end
  end else begin : g_bypass
    assign result_o = sel;
    logic unused_oreg;
    assign unused_oreg = ^{oreg_en_i, oreg_clr_i};
  end
endmodule

// File: tb/tb_dsp_mode_slice.sv
module tb_dsp_mode_slice;
  import dsp_slice_pkg::*;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [71:0] a;
    logic [71:0] b;
    logic        sgn;
    logic [1:0]  sub;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{{18'd2, 18'd7, 18'd5, 18'd3}, {18'd11, 18'd4, 18'd6, 18'd9}, 1'b1, 2'b00},
    '{{18'h3FFFF, 18'h20000, 18'h1FFFF, 18'h3FFFF}, {18'h20000, 18'h20000, 18'h1FFFF, 18'h00005}, 1'b1, 2'b11},
    '{{18'h3FFFF, 18'h20000, 18'h1FFFF, 18'h3FFFF}, {18'h20000, 18'h20000, 18'h1FFFF, 18'h00005}, 1'b0, 2'b01},
    '{{18'h3FF00, 18'h00123, 18'h2ABCD, 18'h15432}, {18'h00FFF, 18'h3FFFF, 18'h12345, 18'h3C000}, 1'b1, 2'b10},
    '{{18'h3FF00, 18'h00123, 18'h2ABCD, 18'h15432}, {18'h00FFF, 18'h3FFFF, 18'h12345, 18'h3C000}, 1'b0, 2'b10},
    '{{4{18'h3FFFF}}, {4{18'h3FFFF}}, 1'b0, 2'b00}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [71:0] a_i = '0, b_i = '0;
  logic signed_i = 1'b0;
  logic [1:0] sub_i = '0;
  logic acc_en_i = 1'b0, acc_clr_i = 1'b0;
  logic [3:0] oreg_en_i = 4'hF, oreg_clr_i = 4'h0;
  logic [143:0] res_mul, res_split, res_mac, res_sum2, res_sum4;

  int checks = 0;
  int fails = 0;
  longint acc_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_mode_slice #(.MODE(MODE_MUL), .SPLIT(1'b0), .OUT_REG(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .signed_i(signed_i), .sub_i(sub_i),
    .acc_en_i(acc_en_i), .acc_clr_i(acc_clr_i), .oreg_en_i(oreg_en_i), .oreg_clr_i(oreg_clr_i),
    .result_o(res_mul));
  dsp_mode_slice #(.MODE(MODE_MUL), .SPLIT(1'b1), .OUT_REG(1'b0)) dut_split (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .signed_i(signed_i), .sub_i(sub_i),
    .acc_en_i(acc_en_i), .acc_clr_i(acc_clr_i), .oreg_en_i(oreg_en_i), .oreg_clr_i(oreg_clr_i),
    .result_o(res_split));
  dsp_mode_slice #(.MODE(MODE_MAC), .OUT_REG(1'b0)) dut_mac (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .signed_i(signed_i), .sub_i(sub_i),
    .acc_en_i(acc_en_i), .acc_clr_i(acc_clr_i), .oreg_en_i(oreg_en_i), .oreg_clr_i(oreg_clr_i),
    .result_o(res_mac));
  dsp_mode_slice #(.MODE(MODE_SUM2), .OUT_REG(1'b0)) dut_sum2 (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .signed_i(signed_i), .sub_i(sub_i),
    .acc_en_i(acc_en_i), .acc_clr_i(acc_clr_i), .oreg_en_i(oreg_en_i), .oreg_clr_i(oreg_clr_i),
    .result_o(res_sum2));
  dsp_mode_slice #(.MODE(MODE_SUM4), .OUT_REG(1'b1)) dut_sum4 (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .signed_i(signed_i), .sub_i(sub_i),
    .acc_en_i(acc_en_i), .acc_clr_i(acc_clr_i), .oreg_en_i(oreg_en_i), .oreg_clr_i(oreg_clr_i),
    .result_o(res_sum4));

  function automatic longint mulx(input logic [17:0] a, input logic [17:0] b, input logic s);
    longint ax, bx;
    ax = s ? longint'($signed(a)) : longint'($unsigned(a));
    bx = s ? longint'($signed(b)) : longint'($unsigned(b));
    return ax * bx;
  endfunction

  function automatic longint mul9(input logic [8:0] a, input logic [8:0] b, input logic s);
    longint ax, bx;
    ax = s ? longint'($signed(a)) : longint'($unsigned(a));
    bx = s ? longint'($signed(b)) : longint'($unsigned(b));
    return ax * bx;
  endfunction

  function automatic logic [143:0] exp_mul(input vec_t v);
    logic [143:0] e;
    for (int i = 0; i < 4; i++) e[36*i +: 36] = 36'(mulx(v.a[18*i +: 18], v.b[18*i +: 18], v.sgn));
    return e;
  endfunction

  function automatic logic [143:0] exp_split(input vec_t v);
    logic [143:0] e;
    for (int i = 0; i < 4; i++) begin
      e[36*i +: 18]      = 18'(mul9(v.a[18*i +: 9], v.b[18*i +: 9], v.sgn));
      e[36*i + 18 +: 18] = 18'(mul9(v.a[18*i + 9 +: 9], v.b[18*i + 9 +: 9], v.sgn));
    end
    return e;
  endfunction

  function automatic longint pair_val(input vec_t v, input int p);
    longint x, y;
    x = mulx(v.a[36*p +: 18], v.b[36*p +: 18], v.sgn);
    y = mulx(v.a[36*p + 18 +: 18], v.b[36*p + 18 +: 18], v.sgn);
    return v.sub[p] ? x - y : x + y;
  endfunction

  function automatic logic [143:0] exp_sum2(input vec_t v);
    logic [143:0] e;
    for (int p = 0; p < 2; p++) e[72*p +: 72] = 72'(pair_val(v, p));
    return e;
  endfunction

  function automatic logic [143:0] exp_acc(input longint m);
    logic [51:0] w;
    w = m[51:0];
    return {{92{w[51]}}, w};
  endfunction

  task automatic chk(input string req, input logic [143:0] act, input logic [143:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    a_i = v.a;
    b_i = v.b;
    signed_i = v.sgn;
    sub_i = v.sub;
  endtask

  task automatic mac_step(input vec_t v, input logic s0, input logic en, input logic clr, input string req);
    longint p;
    drive(v);
    sub_i[0] = s0;
    acc_en_i = en;
    acc_clr_i = clr;
    p = mulx(v.a[17:0], v.b[17:0], v.sgn);
    @(posedge clk);
    if (clr) acc_m = p;
    else if (en) acc_m = s0 ? acc_m - p : acc_m + p;
    @(negedge clk);
    chk(req, res_mac, exp_acc(acc_m));
  endtask

  initial begin
    logic [143:0] e;
    logic [143:0] prev;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset mul", res_mul, '0);
    chk("R11 reset sum4", res_sum4, '0);
    chk("R11 reset mac", res_mac, '0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 6; k++) begin
      drive(VECS[k]);
      #1;
      chk("R12 R2 R3 split comb", res_split, exp_split(VECS[k]));
      chk("R12 R4 R3 sum2 comb", res_sum2, exp_sum2(VECS[k]));
      @(posedge clk);
      @(negedge clk);
      chk("R1 R3 R9 mul reg", res_mul, exp_mul(VECS[k]));
      chk("R5 R3 sum4 reg", res_sum4, 144'(pair_val(VECS[k], 0) + pair_val(VECS[k], 1)));
      chk("R8 mac idle", res_mac, '0);
    end

    // R9: lane 2 disabled keeps old value
    prev = exp_mul(VECS[5]);
    oreg_en_i = 4'b1011;
    drive(VECS[3]);
    @(posedge clk);
    @(negedge clk);
    e = exp_mul(VECS[3]);
    e[72 +: 36] = prev[72 +: 36];
    chk("R9 lane enable", res_mul, e);

    // R10: async clear of lane 1, no clock
    oreg_en_i = 4'hF;
    prev = res_mul;
    oreg_clr_i = 4'b0010;
    drive(VECS[0]);
    #1;
    e = prev;
    e[36 +: 36] = '0;
    chk("R10 async clear", res_mul, e);
    @(posedge clk);
    @(negedge clk);
    e = exp_mul(VECS[0]);
    e[36 +: 36] = '0;
    chk("R10 clear over enable", res_mul, e);
    oreg_clr_i = 4'h0;
    @(posedge clk);
    @(negedge clk);
    chk("R9 reload after clear", res_mul, exp_mul(VECS[0]));

    // Accumulator
    mac_step(VECS[1], 1'b0, 1'b0, 1'b1, "R7 load");
    mac_step(VECS[3], 1'b0, 1'b1, 1'b0, "R6 add");
    mac_step(VECS[4], 1'b1, 1'b1, 1'b0, "R6 sub");
    mac_step(VECS[5], 1'b0, 1'b1, 1'b0, "R6 add unsigned max");
    mac_step(VECS[2], 1'b0, 1'b0, 1'b0, "R8 hold");
    mac_step(VECS[0], 1'b1, 1'b1, 1'b1, "R7 clear priority");

    // R11: asynchronous reset mid-cycle
    acc_clr_i = 1'b0;
    acc_en_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R11 async reset mul", res_mul, '0);
    chk("R11 async reset sum4", res_sum4, '0);
    chk("R11 async reset mac", res_mac, '0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule